// File: doc/BRIEF.md
# Channelised RGB Gamma Lookup

This block applies a per-channel gamma curve to 8-bit RGB pixels for a set of output channels that share one table memory. Software fills the table through two write ports: an address port that also carries an auto-increment flag, and a data port that stores one 8-bit entry per write. The linear table address is `ch*3*N + plane*N + index`, with plane 0 red, 1 green and 2 blue, and N = 2^IDX_W entries per plane.

On the pixel side the block takes a 24-bit pixel with a channel number. It replaces each colour component with its table entry, or passes the pixel through untouched, after a fixed two-cycle delay. The table memory is taken to lose its contents whenever every channel's enable drops low. A per-channel "loaded" flag therefore records that a complete, in-order load of that channel's region has been made since the last such loss. The lookup is used only while both the enable and the loaded flag of the pixel's channel are set.

The write controller is a two-state machine. In WR_IDLE, data writes store entries but earn no credit. In WR_RUN, the machine counts an in-order stream that began at a channel's base. The transitions are:
- IDLE_TO_RUN: an address write with auto-increment set to a channel base.
- RUN_NEXT: the last entry of a region is written while channels remain. The next channel's count starts and the machine stays in WR_RUN.
- RUN_TO_IDLE: the last entry of the last channel is written, any other address write occurs, or the table is lost.

Top module: `gamma_lut`

## Requirements
- R1: While reset is active, and right after it, `pix_out_valid` and `pix_out` are 0 and no channel counts as loaded. An enabled channel therefore passes pixels through unchanged.
- R2: The pixel is `{R[23:16], G[15:8], B[7:0]}`. A looked-up component c of plane p on channel ch returns the entry at address `ch*3*N + p*N + (c >> (8-IDX_W))`.
- R3: When the last address write had auto-increment set, each data write stores at the current address and then adds one to it, wrapping modulo 2^AW.
- R4: When the last address write had auto-increment clear, the address does not move, and repeated data writes overwrite the same entry.
- R5: An address write loads the address and the auto-increment flag on the next clock edge.
- R6: A pixel accepted with `pix_valid` appears on `pix_out` with `pix_out_valid` exactly two clock edges later, in order.
- R7: A pixel whose channel enable is clear leaves the block unchanged.
- R8: A channel is marked loaded only after 3*N consecutive data writes in an auto-increment stream started at that channel's base (address `ch*3*N`). A stream may run on into the following channels, and each completed region is credited. A partial load or an unaligned start earns no credit.
- R9: When the enables go from any set to all clear, every loaded flag is cleared. Loads made while all enables are clear do count, so a channel can be reloaded before it is enabled again.
- R10: A channel that is enabled but not loaded, or a channel number of NUM_CH or more, passes pixels through unchanged.
- R11: Data writes to addresses at or beyond `NUM_CH*3*N` are dropped without touching any entry, although the address still advances under auto-increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_addr_we | input | 1 | Address port write strobe |
| cfg_addr_wdata | input | AW | New table address |
| cfg_addr_autoinc | input | 1 | Auto-increment flag written with the address |
| cfg_data_we | input | 1 | Data port write strobe |
| cfg_data_wdata | input | DW | Table entry to store |
| gamma_en | input | NUM_CH | Per-channel gamma enable |
| pix_valid | input | 1 | Input pixel valid |
| pix_ch | input | CW | Channel of the input pixel |
| pix_in | input | 3*DW | Input pixel {R,G,B} |
| pix_out_valid | output | 1 | Output pixel valid |
| pix_out | output | 3*DW | Output pixel {R,G,B} |

## Verification
The bench builds the block with three channels and IDX_W = 3. This gives 8 entries per plane and a 72-entry table behind a 7-bit address. With these values, a complete load of every channel takes a few hundred cycles, so loss, partial loads, unaligned starts and reloads can all be run in sequence. The unused address range from 72 to 127 lets the bench exercise dropped writes and the wrap of the auto-increment address back to entry 0. The 2-bit channel field leaves channel number 3 free as an invalid channel.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;

    localparam int PLANES = 3;

    typedef enum logic [0:0] {
        WR_IDLE = 1'b0,
        WR_RUN  = 1'b1
    } wr_state_e;

endpackage

// File: rtl/gamma_lut_bank.sv
module gamma_lut_bank #(
    parameter int DEPTH = 768,
    parameter int BW    = 10,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [BW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [BW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/gamma_lut_wrctl.sv
module gamma_lut_wrctl
    import gamma_lut_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int IDX_W  = 8,
    parameter int AW     = 12,
    parameter int CW     = 2,
    parameter int BW     = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_we,
    input  logic [AW-1:0]     addr_wdata,
    input  logic              addr_autoinc,
    input  logic              data_we,
    input  logic [NUM_CH-1:0] gamma_en,
    output logic [AW-1:0]     addr_q,
    output logic              ai_q,
    output logic [NUM_CH-1:0] loaded_q,
    output logic              mem_we,
    output logic [1:0]        mem_plane,
    output logic [BW-1:0]     mem_bank
);

    localparam int N      = 1 << IDX_W;
    localparam int REGION = PLANES * N;
    localparam int TOTAL  = NUM_CH * REGION;
    localparam int CNTW   = $clog2(REGION);

    wr_state_e         state_q, state_d;
    logic [CNTW-1:0]   cnt_q, cnt_d;
    logic [CW-1:0]     run_ch_q, run_ch_d;
    logic [NUM_CH-1:0] done_set;
    logic              any_en_q;
    logic              loss;

    logic [AW-1:0]     cur_grp, cur_ch;
    logic              cur_in_range;
    logic              new_aligned;
    logic [CW-1:0]     new_ch;

    assign loss = any_en_q & ~(|gamma_en);

    // decode of the current address into channel, plane and bank slot
    always_comb begin
        cur_grp      = addr_q >> IDX_W;
        cur_ch       = cur_grp / AW'(PLANES);
        mem_plane    = 2'(cur_grp % AW'(PLANES));
        mem_bank     = BW'(cur_ch) * BW'(N) + BW'(addr_q[IDX_W-1:0]);
        cur_in_range = ({1'b0, addr_q} < (AW+1)'(TOTAL));
        mem_we       = data_we & cur_in_range;
    end

    // decode of an incoming address: is it the base of a channel region
    always_comb begin
        new_ch      = CW'(addr_wdata / AW'(REGION));
        new_aligned = ((addr_wdata % AW'(REGION)) == '0) &&
                      ({1'b0, addr_wdata} < (AW+1)'(TOTAL));
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= WR_IDLE;
            cnt_q    <= '0;
            run_ch_q <= '0;
        end else begin
            state_q  <= state_d;
            cnt_q    <= cnt_d;
            run_ch_q <= run_ch_d;
        end
    end

    // next state and credit
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        run_ch_d = run_ch_q;
        done_set = '0;
        unique case (state_q)
            WR_IDLE: begin
            end
            WR_RUN: begin
                if (data_we) begin
                    if (cnt_q == CNTW'(REGION - 1)) begin
                        done_set[run_ch_q] = 1'b1;
                        cnt_d = '0;
                        if (run_ch_q == CW'(NUM_CH - 1)) begin
                            state_d = WR_IDLE;
                        end else begin
                            run_ch_d = run_ch_q + 1'b1;
                        end
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: state_d = WR_IDLE;
        endcase
        if (addr_we) begin
            cnt_d = '0;
            if (addr_autoinc && new_aligned) begin
                state_d  = WR_RUN;
                run_ch_d = new_ch;
            end else begin
                state_d = WR_IDLE;
            end
        end
        if (loss) begin
            state_d = WR_IDLE;
        end
    end

    // address register, loaded flags, loss detector
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            ai_q     <= 1'b0;
            loaded_q <= '0;
            any_en_q <= 1'b0;
        end else begin
            any_en_q <= |gamma_en;
            loaded_q <= loss ? '0 : (loaded_q | done_set);
            if (addr_we) begin
                addr_q <= addr_wdata;
                ai_q   <= addr_autoinc;
            end else if (data_we && ai_q) begin
                addr_q <= addr_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/gamma_lut.sv
module gamma_lut
    import gamma_lut_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int IDX_W  = 8,
    parameter int DW     = 8,
    parameter int AW     = $clog2(NUM_CH * PLANES * (1 << IDX_W)),
    parameter int CW     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_addr_we,
    input  logic [AW-1:0]     cfg_addr_wdata,
    input  logic              cfg_addr_autoinc,
    input  logic              cfg_data_we,
    input  logic [DW-1:0]     cfg_data_wdata,
    input  logic [NUM_CH-1:0] gamma_en,
    input  logic              pix_valid,
    input  logic [CW-1:0]     pix_ch,
    input  logic [3*DW-1:0]   pix_in,
    output logic              pix_out_valid,
    output logic [3*DW-1:0]   pix_out
);

    localparam int N      = 1 << IDX_W;
    localparam int BANK_D = NUM_CH * N;
    localparam int BW     = (BANK_D > 1) ? $clog2(BANK_D) : 1;
    localparam int PW     = PLANES * DW;

    logic [AW-1:0]     wr_addr;
    logic              wr_ai;
    logic [NUM_CH-1:0] ch_loaded;
    logic              mem_we;
    logic [1:0]        mem_plane;
    logic [BW-1:0]     mem_bank;

    gamma_lut_wrctl #(
        .NUM_CH(NUM_CH), .IDX_W(IDX_W), .AW(AW), .CW(CW), .BW(BW)
    ) u_wrctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_we     (cfg_addr_we),
        .addr_wdata  (cfg_addr_wdata),
        .addr_autoinc(cfg_addr_autoinc),
        .data_we     (cfg_data_we),
        .gamma_en    (gamma_en),
        .addr_q      (wr_addr),
        .ai_q        (wr_ai),
        .loaded_q    (ch_loaded),
        .mem_we      (mem_we),
        .mem_plane   (mem_plane),
        .mem_bank    (mem_bank)
    );

    logic [CW-1:0] rd_ch;
    logic          use_now;
    logic [PW-1:0] lut_word;

    always_comb begin
        rd_ch   = '0;
        use_now = 1'b0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (pix_ch == CW'(c)) begin
                rd_ch   = pix_ch;
                use_now = gamma_en[c] & ch_loaded[c];
            end
        end
    end

    for (genvar p = 0; p < PLANES; p++) begin : g_plane
        logic [DW-1:0] comp;
        logic [BW-1:0] raddr;
        assign comp  = pix_in[PW-1-p*DW -: DW];
        assign raddr = BW'(rd_ch) * BW'(N) + BW'(comp >> (DW - IDX_W));

        gamma_lut_bank #(.DEPTH(BANK_D), .BW(BW), .DW(DW)) u_bank (
            .clk  (clk),
            .we   (mem_we && (mem_plane == 2'(p))),
            .waddr(mem_bank),
            .wdata(cfg_data_wdata),
            .raddr(raddr),
            .rdata(lut_word[PW-1-p*DW -: DW])
        );
    end

    logic          v1_q, use1_q;
    logic [PW-1:0] pix1_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v1_q          <= 1'b0;
            use1_q        <= 1'b0;
            pix1_q        <= '0;
            pix_out_valid <= 1'b0;
            pix_out       <= '0;
        end else begin
            v1_q          <= pix_valid;
            use1_q        <= use_now;
            pix1_q        <= pix_in;
            pix_out_valid <= v1_q;
            pix_out       <= use1_q ? lut_word : pix1_q;
        end
    end

endmodule

// File: rtl/gamma_lut_chk.sv
module gamma_lut_chk #(
    parameter int NUM_CH = 3,
    parameter int DW     = 8,
    parameter int AW     = 12,
    parameter int CW     = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_addr_we,
    input logic [AW-1:0]     cfg_addr_wdata,
    input logic              cfg_data_we,
    input logic [NUM_CH-1:0] gamma_en,
    input logic              pix_valid,
    input logic [CW-1:0]     pix_ch,
    input logic [3*DW-1:0]   pix_in,
    input logic              pix_out_valid,
    input logic [3*DW-1:0]   pix_out,
    input logic [AW-1:0]     wr_addr,
    input logic              wr_ai,
    input logic [NUM_CH-1:0] ch_loaded
);

    logic [1:0] cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cyc <= '0;
        else if (cyc != 2'd3)   cyc <= cyc + 1'b1;
    end

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!pix_out_valid && pix_out == '0 && ch_loaded == '0));

    a_r3_autoinc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_data_we && wr_ai && !cfg_addr_we) |=> wr_addr == AW'($past(wr_addr) + 1'b1));

    a_r4_fixed_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_data_we && !wr_ai && !cfg_addr_we) |=> $stable(wr_addr));

    a_r5_addr_load: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_addr_we |=> wr_addr == $past(cfg_addr_wdata));

    a_r6_two_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd2) |-> pix_out_valid == $past(pix_valid, 2));

    a_r7_bypass_off: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd2 && $past(pix_valid, 2) && $past(gamma_en, 2) == '0)
        |-> pix_out == $past(pix_in, 2));

    a_r10_bad_channel: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd2 && $past(pix_valid, 2) && $past(pix_ch, 2) >= CW'(NUM_CH))
        |-> pix_out == $past(pix_in, 2));

    a_r9_loss_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ((cyc >= 2'd1) && $past(|gamma_en) && !(|gamma_en)) |=> ch_loaded == '0);

endmodule

bind gamma_lut gamma_lut_chk #(
    .NUM_CH(NUM_CH), .DW(DW), .AW(AW), .CW(CW)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_addr_we   (cfg_addr_we),
    .cfg_addr_wdata(cfg_addr_wdata),
    .cfg_data_we   (cfg_data_we),
    .gamma_en      (gamma_en),
    .pix_valid     (pix_valid),
    .pix_ch        (pix_ch),
    .pix_in        (pix_in),
    .pix_out_valid (pix_out_valid),
    .pix_out       (pix_out),
    .wr_addr       (wr_addr),
    .wr_ai         (wr_ai),
    .ch_loaded     (ch_loaded)
);

// File: tb/test_gamma_lut.sv
module test_gamma_lut;

    localparam int NCH   = 3;
    localparam int IW    = 3;
    localparam int N     = 1 << IW;
    localparam int REG   = 3 * N;
    localparam int TOT   = NCH * REG;
    localparam int AW    = 7;
    localparam int CW    = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_addr_we = 1'b0;
    logic [AW-1:0] cfg_addr_wdata = '0;
    logic          cfg_addr_autoinc = 1'b0;
    logic          cfg_data_we = 1'b0;
    logic [7:0]    cfg_data_wdata = '0;
    logic [NCH-1:0] gamma_en = '0;
    logic          pix_valid = 1'b0;
    logic [CW-1:0] pix_ch = '0;
    logic [23:0]   pix_in = '0;
    logic          pix_out_valid;
    logic [23:0]   pix_out;

    always #2.5 clk = ~clk;

    gamma_lut #(.NUM_CH(NCH), .IDX_W(IW), .DW(8)) i_gamma_lut (
        .clk(clk), .rst_n(rst_n),
        .cfg_addr_we(cfg_addr_we), .cfg_addr_wdata(cfg_addr_wdata),
        .cfg_addr_autoinc(cfg_addr_autoinc),
        .cfg_data_we(cfg_data_we), .cfg_data_wdata(cfg_data_wdata),
        .gamma_en(gamma_en),
        .pix_valid(pix_valid), .pix_ch(pix_ch), .pix_in(pix_in),
        .pix_out_valid(pix_out_valid), .pix_out(pix_out)
    );

    typedef struct {
        logic [23:0] exp;
        string       req;
    } item_t;

    item_t    sb[$];
    int       n_chk = 0;
    int       n_bad = 0;
    bit       done = 1'b0;

    logic [7:0] m_mem [TOT];
    int         m_addr = 0;
    bit         m_ai = 1'b0;
    bit [NCH-1:0] m_loaded = '0;
    bit [NCH-1:0] m_en = '0;

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] expect_pix(int ch, logic [23:0] p);
        logic [23:0] r;
        r = p;
        if (ch < NCH && m_en[ch] && m_loaded[ch]) begin
            for (int k = 0; k < 3; k++) begin
                int c;
                c = int'(p[23-8*k -: 8]) >> (8 - IW);
                r[23-8*k -: 8] = m_mem[ch*REG + k*N + c];
            end
        end
        return r;
    endfunction

    function automatic logic [7:0] tv(int c, int p, int i, int salt);
        return 8'((i*37 + p*71 + c*113 + salt) & 255);
    endfunction

    task automatic addr_write(int a, bit ai);
        @(negedge clk);
        cfg_addr_we = 1'b1; cfg_addr_wdata = AW'(a); cfg_addr_autoinc = ai;
        @(negedge clk);
        cfg_addr_we = 1'b0;
        m_addr = a; m_ai = ai;
    endtask

    task automatic data_write(logic [7:0] v);
        @(negedge clk);
        cfg_data_we = 1'b1; cfg_data_wdata = v;
        @(negedge clk);
        cfg_data_we = 1'b0;
        if (m_addr < TOT) m_mem[m_addr] = v;
        if (m_ai) m_addr = (m_addr + 1) % (1 << AW);
    endtask

    task automatic set_en(logic [NCH-1:0] v);
        @(negedge clk);
        gamma_en = v;
        if (m_en != '0 && v == '0) m_loaded = '0;
        m_en = v;
        @(negedge clk);
    endtask

    task automatic pix_set(int ch, logic [23:0] p, string req);
        item_t it;
        @(negedge clk);
        pix_valid = 1'b1; pix_ch = CW'(ch); pix_in = p;
        it.exp = expect_pix(ch, p); it.req = req;
        sb.push_back(it);
    endtask

    task automatic pix_idle();
        @(negedge clk);
        pix_valid = 1'b0;
    endtask

    task automatic pix_one(int ch, logic [23:0] p, string req);
        pix_set(ch, p, req);
        pix_idle();
        repeat (3) @(negedge clk);
    endtask

    // monitor: compares each produced pixel with the queued expectation
    always @(negedge clk) begin
        if (rst_n && pix_out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R6 unexpected output", 32'(pix_out), 32'h0);
            end else begin
                item_t it;
                it = sb.pop_front();
                check(pix_out === it.exp, it.req, 32'(pix_out), 32'(it.exp));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 32'h0, 32'h1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check(pix_out_valid == 1'b0, "R1 valid in reset", 32'(pix_out_valid), 32'h0);
        check(pix_out == '0, "R1 data in reset", 32'(pix_out), 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(pix_out_valid == 1'b0, "R1 valid after reset", 32'(pix_out_valid), 32'h0);

        // R1/R10: enabled but never loaded passes through
        set_en(3'b111);
        pix_one(0, 24'h123456, "R1 R10 unloaded passthrough");

        // R8: one stream from base 0 loads every channel
        set_en(3'b000);
        addr_write(0, 1'b1);
        for (int c = 0; c < NCH; c++)
            for (int p = 0; p < 3; p++)
                for (int i = 0; i < N; i++)
                    data_write(tv(c, p, i, 5));
        m_loaded = 3'b111;
        set_en(3'b111);

        // R2: lookup on every channel, back-to-back burst
        pix_set(0, 24'h00_40_E0, "R2 ch0 lookup");
        pix_set(1, 24'h21_63_A5, "R2 ch1 lookup");
        pix_set(2, 24'hFF_80_1F, "R2 ch2 lookup");
        pix_set(1, 24'hC7_07_5A, "R8 R2 ch1 second");
        pix_idle();
        repeat (3) @(negedge clk);

        // R6: exact latency
        pix_set(2, 24'h3C_5D_7E, "R6 latency data");
        @(negedge clk);
        pix_valid = 1'b0;
        check(pix_out_valid == 1'b0, "R6 not after one edge", 32'(pix_out_valid), 32'h0);
        @(negedge clk);
        check(pix_out_valid == 1'b1, "R6 after two edges", 32'(pix_out_valid), 32'h1);
        repeat (2) @(negedge clk);

        // R7: channel 1 disabled bypasses, channel 0 still looks up
        set_en(3'b101);
        pix_one(1, 24'hAB_CD_EF, "R7 disabled channel bypass");
        pix_one(0, 24'hAB_CD_EF, "R7 enabled neighbour lookup");

        // R10: invalid channel number
        pix_one(3, 24'h99_88_77, "R10 channel out of range");

        // R4: fixed address overwrite (ch0 red index 5)
        set_en(3'b111);
        addr_write(5, 1'b0);
        data_write(8'hA1);
        data_write(8'hB2);
        data_write(8'hC3);
        pix_one(0, 24'hA0_00_00, "R4 last overwrite wins");
        pix_one(0, 24'hC0_00_00, "R4 neighbour untouched");

        // R3: auto-increment (ch2 green index 2 and 3)
        addr_write(2*REG + N + 2, 1'b1);
        data_write(8'h3C);
        data_write(8'h4D);
        pix_one(2, 24'h00_40_00, "R3 first entry");
        pix_one(2, 24'h00_60_00, "R3 incremented entry");

        // R11: out-of-range write dropped; R3: wrap back to entry 0
        addr_write(TOT, 1'b0);
        data_write(8'h5A);
        pix_one(0, 24'h00_00_00, "R11 dropped write");
        addr_write((1 << AW) - 1, 1'b1);
        data_write(8'h11);
        data_write(8'h22);
        pix_one(0, 24'h1F_1F_1F, "R3 R11 wrap to zero");

        // R9: loss of all enables invalidates the table
        set_en(3'b000);
        set_en(3'b001);
        pix_one(0, 24'h40_50_60, "R9 lost table passthrough");

        // R9: reload of ch1 while all disabled counts
        set_en(3'b000);
        addr_write(REG, 1'b1);
        for (int p = 0; p < 3; p++)
            for (int i = 0; i < N; i++)
                data_write(tv(1, p, i, 77));
        m_loaded[1] = 1'b1;
        set_en(3'b011);
        pix_one(1, 24'h12_B4_F6, "R9 reloaded channel");
        pix_one(0, 24'h12_B4_F6, "R8 unloaded channel");

        // R8: partial load earns no credit
        set_en(3'b000);
        addr_write(0, 1'b1);
        for (int k = 0; k < REG - 1; k++)
            data_write(8'(k * 3));
        set_en(3'b001);
        pix_one(0, 24'h81_42_23, "R8 partial load");

        // R8: unaligned stream earns no credit
        set_en(3'b000);
        addr_write(1, 1'b1);
        for (int k = 0; k < REG; k++)
            data_write(8'(k + 100));
        set_en(3'b001);
        pix_one(0, 24'h65_E4_07, "R8 unaligned load");

        repeat (6) @(negedge clk);
        check(sb.size() == 0, "R6 all outputs seen", 32'(sb.size()), 32'h0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule